// File: doc/BRIEF.md
# Activity-Driven Scan Shift Clock Generator

This block produces the shift clock for a single scan chain while a self-test loads a new pattern. It raises the shift rate step by step as long runs of equal bits enter the chain. Every pattern load begins at the slowest rate, on the assumption that the chain still holds a captured response that toggles at every position. Runs of equal adjacent bits lower the toggle activity in the chain, and once enough of them have entered, the next faster rate stays inside the same power budget.

The test controller pulses `startPulse` at the start of each pattern's scan-in and presents the serial bit on `scanIn`. The block samples that bit at each rising edge of `scanClk`. A non-transition is a bit equal to the bit sampled at the previous rising edge. Each time a fixed number of non-transitions has been seen, the speed index moves up by one, and the shift clock period shrinks at its next edge. The slowest rate comes from a separate slow generator, and a multiplexer selects it while the index is 0. A programmable divider serves every faster index.

Top module: `scan_pace_ctrl`

## Requirements
- R1: One system cycle after `startPulse` has been sampled high, `scanClk` is low and `speedIdx` is 0. The first rising edge of `scanClk` follows the start cycle by SLOW_HALF system cycles. Every pattern begins at index 0.
- R2: At index 0, `scanClk` has equal high and low phases of SLOW_HALF system cycles each, so its period is 2*SLOW_HALF.
- R3: At a steady index k of 1 or more, each phase lasts FAST_HALF+NUM_SPEEDS-1-k system cycles. The top index gives FAST_HALF-cycle phases.
- R4: A non-transition is a bit sampled at a rising edge of `scanClk` that is equal to the bit sampled at the previous rising edge of the same pattern. The first bit after a start never counts.
- R5: The step threshold is CHAIN_LEN/NUM_SPEEDS rounded down, and at least 1. Each time the number of non-transitions reaches it, the index rises by one and the count starts again from 0. Transitions between non-transitions do not clear the count.
- R6: A step in index appears on `speedIdx` two system cycles after the rising edge that sampled the deciding bit. The index saturates at NUM_SPEEDS-1, and further steps are ignored.
- R7: When the index rises from 0 to 1, the period that starts at the deciding edge is 2*(FAST_HALF+NUM_SPEEDS-2). A rise from k to k+1 with k of 1 or more gives one period made of the old high phase and the new low phase. No phase of `scanClk` is shorter than FAST_HALF cycles.
- R8: `scanIn` matters only at rising edges of `scanClk`. Changes between those edges have no effect on counting.
- R9: A `startPulse` in the middle of a pattern, at any index, returns the index to 0, clears the count and forgets the previous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle pulse at the start of a pattern's scan-in |
| scanIn | input | 1 | Serial bit entering the chain |
| scanClk | output | 1 | Generated shift clock |
| speedIdx | output | $clog2(NUM_SPEEDS) | Current speed step, 0 is slowest |

## Verification
Every 8-bit pattern is shifted once. This sweep separates patterns by where their non-transitions fall, so it tells an accumulating count apart from one cleared by transitions, and the first bit of a pattern apart from later bits. A long constant pattern drives the index into saturation and checks both kinds of changeover period. An alternating pattern must hold the slowest rate throughout. Between edges the bench briefly drives the wrong bit before settling on the right one, which exposes any sampling outside the rising edge. Back-to-back patterns check that a fresh start undoes a high index.

// File: rtl/scan_pace_pkg.sv
package scan_pace_pkg;
  // Strobes from the control side to the clock datapath
  typedef struct packed {
    logic restart;   // pattern start: clear generators
    logic holdDiv;   // slowest step selected: divider shadows slow clock
  } paceStrobes_t;
endpackage

// File: rtl/scan_pace_fsm.sv
module scan_pace_fsm
  import scan_pace_pkg::*;
#(
  parameter int NUM_SPEEDS  = 4,
  parameter int STEP_THRESH = 3,
  parameter int IDXW        = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            scanIn,
  input  logic            riseNow,
  output paceStrobes_t    strobes,
  output logic [IDXW-1:0] speedIdx
);
  localparam int CW = $clog2(STEP_THRESH + 1);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NUM_SPEEDS - 1);

  logic          prevBit;
  logic          primed;
  logic          speedUpQ;
  logic [CW-1:0] runCnt;
  logic          sameBit;
  logic          wrapNow;

  // Non-transition detector: incoming bit XNOR first chain stage
  assign sameBit = primed && (scanIn ~^ prevBit);
  assign wrapNow = (runCnt == CW'(STEP_THRESH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit  <= 1'b0;
      primed   <= 1'b0;
      runCnt   <= '0;
      speedUpQ <= 1'b0;
    end else if (startPulse) begin
      prevBit  <= 1'b0;
      primed   <= 1'b0;
      runCnt   <= '0;
      speedUpQ <= 1'b0;
    end else begin
      speedUpQ <= 1'b0;
      if (riseNow) begin
        prevBit <= scanIn;
        primed  <= 1'b1;
        if (sameBit) begin
          if (wrapNow) begin
            runCnt   <= '0;
            speedUpQ <= 1'b1;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end
      end
    end
  end

  // Speed step controller, saturating at the fastest step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedIdx <= '0;
    end else if (startPulse) begin
      speedIdx <= '0;
    end else if (speedUpQ && (speedIdx != TOP_IDX)) begin
      speedIdx <= speedIdx + 1'b1;
    end
  end

  assign strobes.restart = startPulse;
  assign strobes.holdDiv = (speedIdx == '0);

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (speedIdx == '0 && runCnt == '0 && !primed));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < CW'(STEP_THRESH));

  // R4
  upstep_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedUpQ |-> $past(riseNow));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> (speedIdx == $past(speedIdx) || speedIdx == $past(speedIdx) + 1'b1));
endmodule

// File: rtl/scan_pace_clkgen.sv
module scan_pace_clkgen
  import scan_pace_pkg::*;
#(
  parameter int NUM_SPEEDS = 4,
  parameter int FAST_HALF  = 2,
  parameter int SLOW_HALF  = 6,
  parameter int IDXW       = 2,
  parameter int HALFW      = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  paceStrobes_t    strobes,
  input  logic [IDXW-1:0] speedIdx,
  output logic            scanClk,
  output logic            riseNow
);
  logic [HALFW-1:0] halfTab [NUM_SPEEDS];

  // Phase length per step: step 0 comes from the slow generator
  for (genvar k = 0; k < NUM_SPEEDS; k++) begin : g_half
    if (k == 0) begin : g_slow
      assign halfTab[k] = HALFW'(SLOW_HALF);
    end else begin : g_div
      assign halfTab[k] = HALFW'(FAST_HALF + NUM_SPEEDS - 1 - k);
    end
  end

  // Slow clock generator
  logic             slowQ;
  logic [HALFW-1:0] slowCnt;
  logic             slowToggle;
  assign slowToggle = (slowCnt == HALFW'(SLOW_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slowQ   <= 1'b0;
      slowCnt <= '0;
    end else if (strobes.restart) begin
      slowQ   <= 1'b0;
      slowCnt <= '0;
    end else if (slowToggle) begin
      slowQ   <= ~slowQ;
      slowCnt <= '0;
    end else begin
      slowCnt <= slowCnt + 1'b1;
    end
  end

  // Programmable divider; ratio latched only on its own edges
  logic             divQ;
  logic [HALFW-1:0] divCnt;
  logic [HALFW-1:0] divHalf;
  logic             divToggle;
  assign divToggle = (divCnt == divHalf - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= 1'b0;
      divCnt  <= '0;
      divHalf <= HALFW'(FAST_HALF + NUM_SPEEDS - 2);
    end else if (strobes.restart) begin
      divQ    <= 1'b0;
      divCnt  <= '0;
      divHalf <= halfTab[1];
    end else if (strobes.holdDiv) begin
      divQ    <= slowQ ^ slowToggle;
      divCnt  <= slowToggle ? '0 : divCnt + 1'b1;
      divHalf <= halfTab[1];
    end else if (divToggle) begin
      divQ    <= ~divQ;
      divCnt  <= '0;
      divHalf <= halfTab[speedIdx];
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Output multiplexer: slowest clock when step 0 is selected
  assign scanClk = strobes.holdDiv ? slowQ : divQ;
  assign riseNow = strobes.holdDiv ? (slowToggle & ~slowQ) : (divToggle & ~divQ);

  // R7
  min_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(scanClk) |=> $stable(scanClk));

  // R7
  handover_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.restart && $fell(strobes.holdDiv)) |-> scanClk);
endmodule

// File: rtl/scan_pace_ctrl.sv
module scan_pace_ctrl
  import scan_pace_pkg::*;
#(
  parameter int CHAIN_LEN  = 12,
  parameter int NUM_SPEEDS = 4,
  parameter int FAST_HALF  = 2,
  parameter int SLOW_HALF  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startPulse,
  input  logic                          scanIn,
  output logic                          scanClk,
  output logic [$clog2(NUM_SPEEDS)-1:0] speedIdx
);
  localparam int IDXW        = $clog2(NUM_SPEEDS);
  localparam int HALFW       = $clog2(SLOW_HALF + 1);
  localparam int STEP_THRESH = (CHAIN_LEN / NUM_SPEEDS < 1) ? 1 : CHAIN_LEN / NUM_SPEEDS;

  paceStrobes_t strobes;
  logic         riseNow;

  scan_pace_fsm #(
    .NUM_SPEEDS (NUM_SPEEDS),
    .STEP_THRESH(STEP_THRESH),
    .IDXW       (IDXW)
  ) fsm_i (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .scanIn    (scanIn),
    .riseNow   (riseNow),
    .strobes   (strobes),
    .speedIdx  (speedIdx)
  );

  scan_pace_clkgen #(
    .NUM_SPEEDS(NUM_SPEEDS),
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF),
    .IDXW      (IDXW),
    .HALFW     (HALFW)
  ) gen_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .speedIdx(speedIdx),
    .scanClk (scanClk),
    .riseNow (riseNow)
  );
endmodule

// File: tb/scan_pace_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_pace_ctrl_tb_top;
  localparam int CL = 12;
  localparam int NS = 4;
  localparam int FH = 2;
  localparam int SH = 6;
  localparam int TH = (CL / NS < 1) ? 1 : CL / NS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       scanIn = 1'b0;
  logic       scanClk;
  logic [1:0] speedIdx;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scan_pace_ctrl #(.CHAIN_LEN(CL), .NUM_SPEEDS(NS), .FAST_HALF(FH), .SLOW_HALF(SH)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .scanIn(scanIn),
    .scanClk(scanClk), .speedIdx(speedIdx)
  );

  function automatic int halfOf(int k);
    return (k == 0) ? SH : FH + NS - 1 - k;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Shift n bits of pattern (bit k at rising edge k) and check timing
  task automatic runVec(input logic [31:0] bits, input int n, input string startReq);
    int idx = 0;
    int run = 0;
    int cyc;
    int expP;
    bit up;
    bit seenLow;
    string pReq;
    string iReq;
    scanIn = bits[0];
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk(scanClk == 1'b0 && speedIdx == 2'd0, startReq, int'(speedIdx), 0);
    cyc = 1;
    while (scanClk != 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == SH + 1, "R1 first edge", cyc, SH + 1);
    for (int k = 0; k < n; k++) begin
      up = 1'b0;
      if (k > 0 && bits[k] == bits[k-1]) begin   // R4 / R5 model
        run++;
        if (run == TH) begin
          run = 0;
          up = 1'b1;
        end
      end
      if (up && idx < NS - 1) begin
        expP = (idx == 0) ? 2 * halfOf(1) : halfOf(idx) + halfOf(idx + 1);
        pReq = "R7";
        idx++;
        iReq = "R5";
      end else begin
        expP = 2 * halfOf(idx);
        pReq = (idx == 0) ? "R2" : "R3";
        iReq = up ? "R6 saturate" : "R5";
      end
      if (k + 1 < n) scanIn = ~bits[k+1];   // R8: wrong value briefly
      @(negedge clk);
      cyc = 1;
      if (k + 1 < n) scanIn = bits[k+1];
      chk(int'(speedIdx) == idx, iReq, int'(speedIdx), idx);
      if (k + 1 < n) begin
        seenLow = 1'b0;
        forever begin
          if (scanClk == 1'b0) seenLow = 1'b1;
          else if (seenLow) break;
          @(negedge clk);
          cyc++;
        end
        chk(cyc == expP, pReq, cyc, expP);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scanClk == 1'b0 && speedIdx == 2'd0, "R1 reset", int'(speedIdx), 0);
    rstN = 1'b1;
    @(negedge clk);
    // long constant run: every step, then saturation (R6)
    runVec(32'h000F_FFFF, 20, "R1");
    // restart from the top step (R9)
    runVec(32'h0000_0AAA, 12, "R9");
    // alternating: stays slowest (R2)
    runVec(32'h0000_0555, 12, "R1");
    // pairs: non-transitions separated by transitions accumulate (R5)
    runVec(32'h0000_0CCC, 12, "R1");
    // all zeros (R4: first bit not counted)
    runVec(32'h0000_0000, 12, "R1");
    // exhaustive 8-bit sweep
    for (int p = 0; p < 256; p++) begin
      runVec(32'(p), 8, "R1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule